// File: doc/BRIEF.md
# Dual-Memory Linked-List Queue Segment Manager

This block keeps the bookkeeping for a buffer of fixed-size segments held in two separate packet memories and shared among many queues. It does not move any payload data. For every queue it keeps a list of segment pointers. Each pointer names a memory (0 or 1) and a segment address inside that memory. A caller issues an enqueue to get a segment address for the next piece of a queue's data. It issues a dequeue to learn which segment to read next and to give that segment back.

Each packet memory has its own link store, with one entry per segment slot, and its own free list. A link entry holds the successor pointer and a flag that marks the last segment of a packet. The queue table holds a head pointer, a tail pointer and a non-empty bit for each queue. New segments go to the memory that has more free space, which keeps the two occupancies balanced. Successive segments of one queue may therefore sit in different memories.

Commands and responses travel on two valid/ready streams. A command is taken in a cycle where `cmd_valid` and `cmd_ready` are both high. Its response appears registered in the next cycle. `cmd_ready` is low only while a response is waiting and `rsp_ready` is low, so a stalled consumer holds back new commands.

Top module: `mq_seg_mgr`

## Requirements
- R1: After reset every queue is empty, `rsp_valid` is 0 and `cmd_ready` is 1. Each free list chains the addresses of its memory in ascending order, so the first allocations in each memory return address 0, then 1, and so on.
- R2: An enqueue (`cmd_op`=0) takes its segment from the memory whose free list is longer. On a tie it takes memory 0. `rsp_mem` reports the memory chosen.
- R3: A segment is always taken from the front of its memory's free list. A released segment is placed at the front, so the next allocation in that memory returns it.
- R4: A dequeue (`cmd_op`=1) returns the queue's segments in the order they were enqueued. `rsp_eop` carries the end-of-packet flag given on the matching enqueue.
- R5: Each queue's order and contents do not depend on commands sent to other queues.
- R6: A dequeue on an empty queue responds with `rsp_err`=1 and `rsp_mem`, `rsp_addr` and `rsp_eop` all 0. It changes no queue and no free list.
- R7: An enqueue while both free lists are empty responds with `rsp_err`=1 and zero fields. It changes no state.
- R8: `cmd_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid` is 1 and `rsp_ready` is 0, all response fields stay unchanged.
- R9: The full capacity of 2×2^SEG_AW segments can be allocated, and every segment becomes allocatable again once it is dequeued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this cycle when high together with cmd_valid |
| cmd_op | input | 1 | 0 = enqueue, 1 = dequeue |
| cmd_qid | input | QW | Queue number |
| cmd_eop | input | 1 | On enqueue: segment ends a packet |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_err | output | 1 | Command rejected (empty queue or no free segment) |
| rsp_mem | output | 1 | Memory index of the segment |
| rsp_addr | output | SEG_AW | Segment address inside that memory |
| rsp_eop | output | 1 | End-of-packet flag of the segment |

## Verification
The bench keeps its own model: two free stacks seeded in ascending order and one FIFO per queue. It predicts every response arithmetically. A fill sweep cycles through all queues until all segments are allocated. This shows the alternating memory choice and the exact free-list order, and it then exposes the overflow rejection. An out-of-order drain across queues separates per-queue FIFO order from global order. A long pseudo-random mix of enqueues and dequeues makes the two occupancies uneven, which tests the longer-list rule and the reuse of freed segments at the front of the list. Random response stalls test that the response holds steady and that `cmd_ready` follows `rsp_ready`.

// File: rtl/mqsm_pkg.sv
package mqsm_pkg;
  typedef enum logic {
    OP_ENQ = 1'b0,
    OP_DEQ = 1'b1
  } mq_op_e;

  localparam int NUM_MEMS = 2;
endpackage

// File: rtl/mqsm_seg_pool.sv
module mqsm_seg_pool #(
  parameter int SEG_AW = 3,
  parameter bit MEM_ID = 1'b0,
  localparam int DEPTH = 1 << SEG_AW,
  localparam int PW = SEG_AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic              alloc_eop,
  output logic [SEG_AW-1:0] alloc_addr,
  output logic [SEG_AW:0]   free_cnt,
  input  logic              link_en,
  input  logic [SEG_AW-1:0] link_addr,
  input  logic [PW-1:0]     link_ptr,
  input  logic              rel_en,
  input  logic [SEG_AW-1:0] rel_addr,
  input  logic [SEG_AW-1:0] rd_addr,
  output logic [PW-1:0]     rd_ptr,
  output logic              rd_eop
);
  logic [PW-1:0]     nxt  [DEPTH];
  logic              eopf [DEPTH];
  logic [SEG_AW-1:0] fhead;
  logic [SEG_AW:0]   cnt;

  assign alloc_addr = fhead;
  assign free_cnt   = cnt;
  assign rd_ptr     = nxt[rd_addr];
  assign rd_eop     = eopf[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        nxt[i]  <= {MEM_ID, SEG_AW'(i + 1)};
        eopf[i] <= 1'b0;
      end
      fhead <= '0;
      cnt   <= (SEG_AW+1)'(DEPTH);
    end else begin
      if (alloc_en) begin
        eopf[fhead] <= alloc_eop;
        fhead       <= nxt[fhead][SEG_AW-1:0];
        cnt         <= cnt - 1'b1;
      end
      if (link_en) begin
        nxt[link_addr] <= link_ptr;
      end
      if (rel_en) begin
        nxt[rel_addr] <= {MEM_ID, fhead};
        fhead         <= rel_addr;
        cnt           <= cnt + 1'b1;
      end
    end
  end

  // R7: never allocate from an exhausted list
  a_r7_no_alloc_empty: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> (cnt != '0));

  // R9: the free count never exceeds the memory size
  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (SEG_AW+1)'(DEPTH));

  // R3: a released slot becomes the next one handed out
  a_r3_release_front: assert property (@(posedge clk) disable iff (!rst_n)
    rel_en |=> (alloc_addr == $past(rel_addr)));
endmodule

// File: rtl/mqsm_pick.sv
module mqsm_pick #(
  parameter int SEG_AW = 3
) (
  input  logic [SEG_AW:0] cnt0,
  input  logic [SEG_AW:0] cnt1,
  output logic            tgt,
  output logic            none
);
  always_comb begin
    none = (cnt0 == '0) && (cnt1 == '0);
    tgt  = (cnt1 > cnt0);
  end
endmodule

// File: rtl/mqsm_qtab.sv
module mqsm_qtab #(
  parameter int NQ = 4,
  parameter int SEG_AW = 3,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int PW = SEG_AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [QW-1:0] qid,
  output logic [PW-1:0] head,
  output logic [PW-1:0] tail,
  output logic          qvalid,
  input  logic          enq_en,
  input  logic [PW-1:0] enq_ptr,
  input  logic          deq_en,
  input  logic [PW-1:0] deq_next
);
  logic [PW-1:0] hd [NQ];
  logic [PW-1:0] tl [NQ];
  logic [NQ-1:0] qv;

  assign head   = hd[qid];
  assign tail   = tl[qid];
  assign qvalid = qv[qid];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NQ; i++) begin
        hd[i] <= '0;
        tl[i] <= '0;
      end
      qv <= '0;
    end else begin
      if (enq_en) begin
        tl[qid] <= enq_ptr;
        if (!qv[qid]) begin
          hd[qid] <= enq_ptr;
          qv[qid] <= 1'b1;
        end
      end
      if (deq_en) begin
        if (hd[qid] == tl[qid]) qv[qid] <= 1'b0;
        else                    hd[qid] <= deq_next;
      end
    end
  end

  // R4: an enqueue always leaves its queue non-empty with the new tail
  a_r4_enq_tail: assert property (@(posedge clk) disable iff (!rst_n)
    enq_en |=> (qv[$past(qid)] && tl[$past(qid)] == $past(enq_ptr)));
endmodule

// File: rtl/mq_seg_mgr.sv
module mq_seg_mgr
  import mqsm_pkg::*;
#(
  parameter int NQ = 4,
  parameter int SEG_AW = 3,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int PW = SEG_AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_op,
  input  logic [QW-1:0]     cmd_qid,
  input  logic              cmd_eop,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_err,
  output logic              rsp_mem,
  output logic [SEG_AW-1:0] rsp_addr,
  output logic              rsp_eop
);
  logic [SEG_AW:0]   fcnt   [NUM_MEMS];
  logic [SEG_AW-1:0] fhead  [NUM_MEMS];
  logic [PW-1:0]     rdnext [NUM_MEMS];
  logic              rdeop  [NUM_MEMS];

  logic [PW-1:0] q_head, q_tail, new_ptr;
  logic          q_valid, tgt, none;
  logic          fire, is_enq, enq_ok, deq_ok;

  assign cmd_ready = !rsp_valid || rsp_ready;
  assign fire      = cmd_valid && cmd_ready;
  assign is_enq    = (mq_op_e'(cmd_op) == OP_ENQ);
  assign enq_ok    = fire && is_enq && !none;
  assign deq_ok    = fire && !is_enq && q_valid;
  assign new_ptr   = {tgt, fhead[tgt]};

  mqsm_pick #(.SEG_AW(SEG_AW)) pick_i (
    .cnt0(fcnt[0]), .cnt1(fcnt[1]), .tgt(tgt), .none(none)
  );

  mqsm_qtab #(.NQ(NQ), .SEG_AW(SEG_AW)) qtab_i (
    .clk(clk), .rst_n(rst_n), .qid(cmd_qid),
    .head(q_head), .tail(q_tail), .qvalid(q_valid),
    .enq_en(enq_ok), .enq_ptr(new_ptr),
    .deq_en(deq_ok), .deq_next(rdnext[q_head[SEG_AW]])
  );

  for (genvar g = 0; g < NUM_MEMS; g++) begin : g_pool
    mqsm_seg_pool #(.SEG_AW(SEG_AW), .MEM_ID(g[0])) pool_i (
      .clk(clk), .rst_n(rst_n),
      .alloc_en(enq_ok && (tgt == g[0])),
      .alloc_eop(cmd_eop),
      .alloc_addr(fhead[g]),
      .free_cnt(fcnt[g]),
      .link_en(enq_ok && q_valid && (q_tail[SEG_AW] == g[0])),
      .link_addr(q_tail[SEG_AW-1:0]),
      .link_ptr(new_ptr),
      .rel_en(deq_ok && (q_head[SEG_AW] == g[0])),
      .rel_addr(q_head[SEG_AW-1:0]),
      .rd_addr(q_head[SEG_AW-1:0]),
      .rd_ptr(rdnext[g]),
      .rd_eop(rdeop[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_mem   <= 1'b0;
      rsp_addr  <= '0;
      rsp_eop   <= 1'b0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      if (enq_ok) begin
        rsp_err  <= 1'b0;
        rsp_mem  <= tgt;
        rsp_addr <= fhead[tgt];
        rsp_eop  <= cmd_eop;
      end else if (deq_ok) begin
        rsp_err  <= 1'b0;
        rsp_mem  <= q_head[SEG_AW];
        rsp_addr <= q_head[SEG_AW-1:0];
        rsp_eop  <= rdeop[q_head[SEG_AW]];
      end else begin
        rsp_err  <= 1'b1;
        rsp_mem  <= 1'b0;
        rsp_addr <= '0;
        rsp_eop  <= 1'b0;
      end
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R8: a stalled response holds all its fields
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable({rsp_err, rsp_mem, rsp_addr, rsp_eop})));

  // R6: a dequeue of an empty queue is answered with an error
  a_r6_empty_err: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !is_enq && !q_valid) |=> (rsp_valid && rsp_err));

  // R2: the chosen memory never has the shorter free list
  a_r2_balance: assert property (@(posedge clk) disable iff (!rst_n)
    enq_ok |-> (fcnt[tgt] >= fcnt[!tgt]));
endmodule

// File: tb/mq_seg_mgr_tb_top.sv
module mq_seg_mgr_tb_top;
  localparam int NQ = 4;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;
  localparam int QW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_op = 1'b0, cmd_eop = 1'b0, rsp_ready = 1'b1;
  logic [QW-1:0] cmd_qid = '0;
  logic cmd_ready, rsp_valid, rsp_err, rsp_mem, rsp_eop;
  logic [AW-1:0] rsp_addr;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 1'b0;

  int fstk [2][DEPTH];
  int fsz  [2];
  int qmem [NQ][2*DEPTH];
  int qadr [NQ][2*DEPTH];
  int qeop [NQ][2*DEPTH];
  int qhd  [NQ];
  int qn   [NQ];
  int unsigned seed = 32'h1234_5678;

  always #2 clk = ~clk;

  mq_seg_mgr #(.NQ(NQ), .SEG_AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_qid(cmd_qid), .cmd_eop(cmd_eop),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_err(rsp_err),
    .rsp_mem(rsp_mem), .rsp_addr(rsp_addr), .rsp_eop(rsp_eop)
  );

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  function automatic int pack_rsp(int e, int m, int a, int p);
    return (e << 8) | (m << 7) | (a << 1) | p;
  endfunction

  function automatic int unsigned rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic model_reset();
    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k < DEPTH; k++) fstk[m][k] = DEPTH - 1 - k;
      fsz[m] = DEPTH;
    end
    for (int q = 0; q < NQ; q++) begin
      qhd[q] = 0;
      qn[q] = 0;
    end
  endtask

  function automatic int model_cmd(int op, int q, int eop);
    int m, a, p, slot;
    if (op == 0) begin
      if (fsz[0] == 0 && fsz[1] == 0) return pack_rsp(1, 0, 0, 0);
      m = (fsz[1] > fsz[0]) ? 1 : 0;
      fsz[m]--;
      a = fstk[m][fsz[m]];
      slot = (qhd[q] + qn[q]) % (2*DEPTH);
      qmem[q][slot] = m;
      qadr[q][slot] = a;
      qeop[q][slot] = eop;
      qn[q]++;
      return pack_rsp(0, m, a, eop);
    end
    if (qn[q] == 0) return pack_rsp(1, 0, 0, 0);
    m = qmem[q][qhd[q]];
    a = qadr[q][qhd[q]];
    p = qeop[q][qhd[q]];
    qhd[q] = (qhd[q] + 1) % (2*DEPTH);
    qn[q]--;
    fstk[m][fsz[m]] = a;
    fsz[m]++;
    return pack_rsp(0, m, a, p);
  endfunction

  task automatic do_cmd(string req, int op, int q, int eop, int stall);
    int exp, got, held;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op = op[0];
    cmd_qid = q[QW-1:0];
    cmd_eop = eop[0];
    rsp_ready = (stall == 0);
    while (!cmd_ready) @(negedge clk);
    exp = model_cmd(op, q, eop);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    got = pack_rsp(rsp_err, rsp_mem, rsp_addr, rsp_eop);
    if (stall > 0) begin
      held = got;
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        check("R8 hold", pack_rsp(rsp_err, rsp_mem, rsp_addr, rsp_eop), held);
        check("R8 ready low", {rsp_valid, cmd_ready}, 2'b10);
      end
      rsp_ready = 1'b1;
    end
    check("R8 valid", rsp_valid, 1);
    check(req, got, exp);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: got %0d cycles expected under 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 rsp_valid", rsp_valid, 0);
    check("R1 cmd_ready", cmd_ready, 1);

    // R6 on every fresh queue (also confirms R1 empty queues)
    for (int q = 0; q < NQ; q++) do_cmd("R6 empty dequeue", 1, q, 0, 0);

    // R1/R2/R3: fill sweep, memories alternate, addresses ascend
    for (int i = 0; i < 2*DEPTH; i++) begin
      do_cmd("R2 fill enqueue", 0, i % NQ, (i % 3 == 2) ? 1 : 0, 0);
      check("R1 ascending order", {rsp_mem, rsp_addr}, {i[0], i[AW:1]});
    end
    // R7: overflow rejected, then state unchanged
    do_cmd("R7 full enqueue", 0, 1, 1, 0);
    do_cmd("R7 full enqueue again", 0, 3, 0, 2);

    // R4/R5: drain queues out of order
    for (int r = 0; r < NQ; r++)
      for (int k = 0; k < 2*DEPTH/NQ; k++)
        do_cmd("R5 drain", 1, (r * 3 + 1) % NQ, 0, 0);
    do_cmd("R6 after drain", 1, 2, 0, 0);

    // R3: a released segment is reused first
    do_cmd("R3 enq", 0, 0, 1, 0);
    do_cmd("R3 deq", 1, 0, 0, 0);
    do_cmd("R3 reuse", 0, 2, 0, 0);

    // R2/R4/R8: random mix with stalls
    for (int i = 0; i < 3000; i++) begin
      int unsigned r = rnd();
      do_cmd("R4 random", ((r & 7) < 4) ? 0 : 1, int'((r >> 4) % NQ),
             int'((r >> 8) & 1), ((r >> 12) % 8 == 0) ? int'((r >> 16) % 3) + 1 : 0);
    end

    // R9: drain everything, then the full capacity is available
    for (int q = 0; q < NQ; q++)
      while (qn[q] > 0) do_cmd("R9 drain", 1, q, 0, 0);
    for (int i = 0; i < 2*DEPTH; i++) begin
      do_cmd("R9 refill", 0, 3, 0, 0);
      check("R9 not rejected", rsp_err, 0);
    end
    do_cmd("R7 refill overflow", 0, 0, 0, 0);

    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule